// File: doc/BRIEF.md
# UART Auto-Baud Calibrator with Confirmation Handshake

This block finds the bit period of a serial host that is not yet known. The host keeps sending the calibration byte 0x00 in 8N1 framing. In that frame the start bit and all eight data bits are low, so the line stays low for exactly nine bit times before the stop bit. The block passes the receive line through a two-stage synchroniser and counts the system clocks of that low run. It divides the count by nine, rounded to nearest, to get a clocks-per-bit divisor.

Once the divisor is known, the block sends one 0x00 byte back to the host at the new rate. It then waits for a single reply byte at the same rate and samples each bit at its middle. The reply 0x55 with a valid stop bit sets the locked flag. Any other reply sets the error flag. Both outcomes are final until the next reset, and a reset restarts detection from the beginning.

Low runs that are too short to be a real calibration frame are dropped without any action. So are runs that overflow the counter. In both cases the block waits for the next frame.

Top module: `autobaud_sync`

## Requirements
- R1: After reset, tx is high, locked, error and div_ready are low, and divisor is 0.
- R2: Detection starts only after the synchronised line has been seen high. The block times the first low run that follows, L clocks long, and reports divisor = floor((L+4)/9). It marks the new value with a div_ready pulse that lasts exactly one clock.
- R3: A low run shorter than MIN_LOW clocks gives no div_ready and no transmission. The next valid frame is then measured normally, and the accepted divisor is never below (MIN_LOW+4)/9.
- R4: A low run that is still low after 2^CNT_W-1 counted clocks is discarded. The block gives no div_ready, waits for the line to go high, and then measures the next frame.
- R5: After div_ready, tx sends one 8N1 byte 0x00 at the divisor rate: a start bit, eight zero data bits sent LSB first, and a high stop bit. tx is therefore low for exactly 9 × divisor clocks, starting in the cycle where div_ready is high.
- R6: After that transmission, a reply byte arriving LSB first with bits of divisor clocks is sampled near the middle of each bit. The value 0x55 with a high stop bit sets locked.
- R7: A reply whose eight data bits are not 0x55 sets error, and locked stays low.
- R8: A reply whose stop bit is sampled low sets error, even when the data bits are 0x55.
- R9: Once locked or error is set, further frames on rx change neither flag, the divisor, nor tx, which stays high. Only a reset starts detection again.
- R10: locked and error are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx | input | 1 | Asynchronous serial receive line from the host |
| tx | output | 1 | Serial transmit line to the host, high when idle |
| divisor | output | CNT_W | Derived clocks per bit |
| div_ready | output | 1 | One-clock strobe when a new divisor is available |
| locked | output | 1 | Handshake finished with the expected reply |
| error | output | 1 | Handshake failed on a wrong reply byte or a bad stop bit |

## Verification
The bench picks the low-run length so that the remainder of the division by nine lands on both sides of the rounding point. A design that truncates, or that is one count off in the synchroniser path, would report a divisor one too small or one too large. The length of the returned 0x00 frame is measured to the exact clock, which catches a transmitter that is one count off per bit. Runs that are too short and runs that overflow the counter are each followed by a good frame, so a design that locked onto noise, or hung after a discard, shows up as a wrong divisor or a missing strobe. The reply is sent as 0x55, as a random wrong byte, or as 0x55 with a low stop bit. Extra frames after the outcome check that the result never flips back and that tx stays high.

// File: rtl/autobaud_sync.sv
module autobaud_sync #(
  parameter int CNT_W = 16,
  parameter int MIN_LOW = 36,
  parameter logic [7:0] ACK_BYTE = 8'h00,
  parameter logic [7:0] REPLY_BYTE = 8'h55
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx,
  output logic             tx,
  output logic [CNT_W-1:0] divisor,
  output logic             div_ready,
  output logic             locked,
  output logic             error
);
  localparam int NUM_W = CNT_W + 1;
  localparam int ITER_W = $clog2(NUM_W + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(MIN_LOW);
  localparam logic [9:0] TX_FRAME = {1'b1, ACK_BYTE, 1'b0};

  typedef enum logic [3:0] {
    S_WAIT_HIGH, S_ARMED, S_MEASURE, S_DIV, S_TX,
    S_RX_IDLE, S_RX, S_LOCKED, S_FAIL
  } state_t;

  state_t st;
  logic [1:0] sync;
  logic [CNT_W-1:0] cnt, tmr;
  logic [NUM_W-1:0] dq;
  logic [3:0] rem;
  logic [ITER_W-1:0] iter;
  logic [3:0] bitn;
  logic [7:0] sh;

  wire rx_s = sync[1];
  wire [4:0] trial = {rem, dq[NUM_W-1]};
  wire fit = trial >= 5'd9;
  wire [4:0] diff = trial - 5'd9;
  wire [NUM_W-1:0] q_next = {dq[NUM_W-2:0], fit};
  wire [CNT_W-1:0] half = divisor >> 1;
  wire bit_end = tmr == divisor - 1'b1;

  assign tx = (st != S_TX) || TX_FRAME[bitn];
  assign locked = st == S_LOCKED;
  assign error = st == S_FAIL;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_WAIT_HIGH;
      sync <= 2'b00;
      cnt <= '0;
      tmr <= '0;
      dq <= '0;
      rem <= '0;
      iter <= '0;
      bitn <= '0;
      sh <= '0;
      divisor <= '0;
      div_ready <= 1'b0;
    end else begin
      sync <= {sync[0], rx};
      div_ready <= 1'b0;
      case (st)
        S_WAIT_HIGH: if (rx_s) st <= S_ARMED;
        S_ARMED: if (!rx_s) begin
          cnt <= CNT_W'(1);
          st <= S_MEASURE;
        end
        S_MEASURE: begin
          if (rx_s) begin
            if (cnt < MIN_CNT) begin
              st <= S_ARMED;
            end else begin
              dq <= {1'b0, cnt} + NUM_W'(4);
              rem <= '0;
              iter <= '0;
              st <= S_DIV;
            end
          end else if (cnt == CNT_MAX) begin
            st <= S_WAIT_HIGH;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DIV: begin
          rem <= fit ? diff[3:0] : trial[3:0];
          dq <= q_next;
          iter <= iter + 1'b1;
          if (iter == ITER_W'(NUM_W - 1)) begin
            divisor <= q_next[CNT_W-1:0];
            div_ready <= 1'b1;
            tmr <= '0;
            bitn <= '0;
            st <= S_TX;
          end
        end
        S_TX: begin
          if (bit_end) begin
            tmr <= '0;
            if (bitn == 4'd9) st <= S_RX_IDLE;
            else bitn <= bitn + 1'b1;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        S_RX_IDLE: if (!rx_s) begin
          tmr <= '0;
          bitn <= '0;
          st <= S_RX;
        end
        S_RX: begin
          if (bitn == 4'd0) begin
            if (tmr == half) begin
              tmr <= '0;
              if (rx_s) st <= S_RX_IDLE;
              else bitn <= 4'd1;
            end else begin
              tmr <= tmr + 1'b1;
            end
          end else if (bit_end) begin
            tmr <= '0;
            if (bitn == 4'd9) begin
              st <= (rx_s && sh == REPLY_BYTE) ? S_LOCKED : S_FAIL;
            end else begin
              sh <= {rx_s, sh[7:1]};
              bitn <= bitn + 1'b1;
            end
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        S_LOCKED: st <= S_LOCKED;
        S_FAIL: st <= S_FAIL;
        default: st <= S_WAIT_HIGH;
      endcase
    end
  end
endmodule

module autobaud_sync_sva #(
  parameter int CNT_W = 16,
  parameter int MIN_LOW = 36
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx,
  input logic [CNT_W-1:0] divisor,
  input logic             div_ready,
  input logic             locked,
  input logic             error
);
  localparam logic [CNT_W-1:0] DIV_MIN = CNT_W'((MIN_LOW + 4) / 9);

  assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(locked && error));
  assert_ready_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    div_ready |=> !div_ready);
  assert_div_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    div_ready |-> divisor >= DIV_MIN);
  assert_tx_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    div_ready |-> !tx);
  assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked && $stable(divisor));
  assert_error_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> error && $stable(divisor));
  assert_quiet_tx_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (locked || error) |-> tx);
endmodule

bind autobaud_sync autobaud_sync_sva #(.CNT_W(CNT_W), .MIN_LOW(MIN_LOW)) u_sva (
  .clk(clk), .rst_n(rst_n), .tx(tx), .divisor(divisor),
  .div_ready(div_ready), .locked(locked), .error(error)
);

// File: tb/sim_autobaud_sync.sv
module sim_autobaud_sync;
  localparam int CNT_W = 12;
  localparam int MIN_LOW = 36;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1;
  logic tx, div_ready, locked, error;
  logic [CNT_W-1:0] divisor;

  int total = 0;
  int fails = 0;
  int dr_cnt = 0;
  int txl_cnt = 0;
  logic clr_mon = 1'b1;

  always #10 clk = ~clk;

  autobaud_sync #(.CNT_W(CNT_W), .MIN_LOW(MIN_LOW)) u0 (
    .clk(clk), .rst_n(rst_n), .rx(rx), .tx(tx), .divisor(divisor),
    .div_ready(div_ready), .locked(locked), .error(error)
  );

  always @(negedge clk) begin
    if (clr_mon) begin
      dr_cnt = 0;
      txl_cnt = 0;
    end else begin
      if (div_ready) dr_cnt = dr_cnt + 1;
      if (!tx) txl_cnt = txl_cnt + 1;
    end
  end

  function automatic int exp_div(input int low_len);
    return (low_len + 4) / 9;
  endfunction

  task automatic check_eq(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic hold(input logic level, input int n);
    rx = level;
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_mon();
    clr_mon = 1'b1;
    @(negedge clk);
    @(negedge clk);
    clr_mon = 1'b0;
  endtask

  task automatic do_reset();
    rx = 1'b1;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, input int p, input logic stop);
    hold(1'b0, p);
    for (int i = 0; i < 8; i++) hold(b[i], p);
    hold(stop, p);
    rx = 1'b1;
  endtask

  task automatic run_trial(input int p, input int k, input int kind);
    int len, d;
    logic [7:0] reply;
    len = 9 * p + k;
    d = exp_div(len);
    do_reset();
    clear_mon();
    hold(1'b1, 10);
    hold(1'b0, len);
    hold(1'b1, 12 * d + 30);
    check_eq("R2 div_ready pulses", dr_cnt, 1);
    check_eq("R2 divisor", int'(divisor), d);
    check_eq("R5 tx low clocks", txl_cnt, 9 * d);
    check_eq("R5 tx idle after ack", int'(tx), 1);
    reply = 8'h55;
    if (kind == 1) begin
      reply = 8'($urandom);
      if (reply == 8'h55) reply = 8'h54;
    end
    send_byte(reply, d, kind != 2);
    hold(1'b1, 3 * d);
    if (kind == 0) begin
      check_eq("R6 locked", int'(locked), 1);
      check_eq("R6 error", int'(error), 0);
    end else if (kind == 1) begin
      check_eq("R7 error", int'(error), 1);
      check_eq("R7 locked", int'(locked), 0);
    end else begin
      check_eq("R8 error", int'(error), 1);
      check_eq("R8 locked", int'(locked), 0);
    end
    check_eq("R10 exclusive", int'(locked && error), 0);
    clear_mon();
    hold(1'b0, 9 * d);
    hold(1'b1, 12 * d + 30);
    send_byte(8'h55, d, 1'b1);
    hold(1'b1, 3 * d);
    check_eq("R9 no new strobe", dr_cnt, 0);
    check_eq("R9 tx quiet", txl_cnt, 0);
    check_eq("R9 divisor kept", int'(divisor), d);
    check_eq("R9 locked kept", int'(locked), kind == 0 ? 1 : 0);
    check_eq("R9 error kept", int'(error), kind == 0 ? 0 : 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    check_eq("R1 tx", int'(tx), 1);
    check_eq("R1 locked", int'(locked), 0);
    check_eq("R1 error", int'(error), 0);
    check_eq("R1 div_ready", int'(div_ready), 0);
    check_eq("R1 divisor", int'(divisor), 0);

    clear_mon();
    hold(1'b1, 10);
    hold(1'b0, 20);
    hold(1'b1, 200);
    check_eq("R3 short run no strobe", dr_cnt, 0);
    check_eq("R3 short run no tx", txl_cnt, 0);
    hold(1'b0, 72);
    hold(1'b1, 150);
    check_eq("R3 next frame strobe", dr_cnt, 1);
    check_eq("R3 next frame divisor", int'(divisor), 8);

    do_reset();
    clear_mon();
    hold(1'b1, 10);
    hold(1'b0, 5000);
    hold(1'b1, 200);
    check_eq("R4 overflow no strobe", dr_cnt, 0);
    check_eq("R4 overflow no tx", txl_cnt, 0);
    hold(1'b0, 63);
    hold(1'b1, 150);
    check_eq("R4 next frame strobe", dr_cnt, 1);
    check_eq("R4 next frame divisor", int'(divisor), 7);

    run_trial(10, 4, 0);
    run_trial(10, 5, 1);
    run_trial(12, -4, 2);
    for (int t = 0; t < 6; t++) begin
      run_trial(5 + int'($urandom % 56), int'($urandom % 9) - 4, int'($urandom % 3));
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule